// File: doc/BRIEF.md
# Eight-Pin GPIO Port Controller with Peripheral Override

The block controls a port of general-purpose pins, eight by default. Software reaches four writable per-pin registers through a small register bus: peripheral select, direction, output data and pull-up request. A read-only input register shows the sampled pin levels. Every register holds one bit per pin, so each pin is configured on its own.

For each pin the controller picks the source of the pad drive. In software mode the direction and output-data bits set the pad output enable and the pad output value. In peripheral mode the on-chip peripheral's data and enable inputs take over both. A weak pull-up is requested only in software mode and only while the output driver is off.

Pad inputs pass through a two-flop synchronizer before they reach the input register. Reset returns every pin to a software-mode input with no pull-up. Reset leaves the output-data register as it was.

Top module: `gpio_port`

## Requirements
- R1: One cycle after synchronous reset is released, the select, direction and pull-up registers read 0, and `pad_oe` and `pad_pu` are all 0.
- R2: With a pin's select bit at 0, its `pad_oe` equals its direction bit (1 = drive, 0 = high impedance) and its `pad_out` equals its output-data bit.
- R3: With a pin's select bit at 1, its `pad_oe` equals `periph_oe` and its `pad_out` equals `periph_out` for that pin, whatever the direction and output-data bits hold.
- R4: A pin's `pad_pu` is 1 exactly when its pull-up bit is 1, its select bit is 0 and its direction bit is 0. `pad_pu` and `pad_oe` are never both 1 on the same pin.
- R5: Asserting reset does not change the output-data register. A value written before reset reads back unchanged after it.
- R6: Reading the output-data register returns the last value written to it, even when the pad is driven by a peripheral or the pin level differs.
- R7: The input register shows the pad level after two synchronizer flops. This holds whether the pin drives or not. With the read address already held, a pad change shows on `rd_data` three clock edges after it is applied.
- R8: A write to the input-register address (3) changes no register. Reads of the unused addresses 5, 6 and 7 return 0.
- R9: The register addresses are 0 select, 1 direction, 2 output data, 3 input and 4 pull-up. `rd_data` is registered and presents the addressed register one edge after the address. A read in the same cycle as a write to that address returns the value from before the write.
- R10: `pad_out`, `pad_oe` and `pad_pu` are registered. They follow a register write or a peripheral input change one clock edge after the register or input itself changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register bus |
| addr | input | 3 | Register address |
| wr_data | input | NPINS | Write data, one bit per pin |
| rd_data | output | NPINS | Registered read data |
| periph_out | input | NPINS | Peripheral output value per pin |
| periph_oe | input | NPINS | Peripheral output enable per pin |
| pad_in | input | NPINS | Asynchronous pad level |
| pad_out | output | NPINS | Pad output value |
| pad_oe | output | NPINS | Pad output enable |
| pad_pu | output | NPINS | Weak pull-up enable |

## Verification
A register write and a read of the same address can share a cycle. The bench provokes this by holding the address during a write strobe. It then expects `rd_data` at the next falling edge to hold the value from before the write, and the following read to return the new value. A register write and the update of the registered pad outputs can also overlap. The bench checks that a direction write has not yet moved `pad_oe` when the write cycle ends, and that `pad_oe` takes the new value one edge later. A sweep over all 64 combinations of select, direction, pull-up, output data and the peripheral inputs, offset differently on each pin, checks the pad equations together.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_SEL  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_DIR  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_DOUT = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_DIN  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_PU   = 3'd4;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;

  // R7
  sync_two_stage_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (stage2_q == $past(stage1_q)));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPINS-1:0]  wr_data,
  input  logic [NPINS-1:0]  din_sync,
  output logic [NPINS-1:0]  sel_q,
  output logic [NPINS-1:0]  dir_q,
  output logic [NPINS-1:0]  dout_q,
  output logic [NPINS-1:0]  pu_q,
  output logic [NPINS-1:0]  rd_data
);
  logic [NPINS-1:0] rd_next;

  // Configuration registers cleared by reset
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      dir_q <= '0;
      pu_q  <= '0;
    end else if (wr_en) begin
      if (addr == ADDR_SEL) sel_q <= wr_data;
      if (addr == ADDR_DIR) dir_q <= wr_data;
      if (addr == ADDR_PU)  pu_q  <= wr_data;
    end
  end

  // Output data register: reset deliberately leaves it alone
  always_ff @(posedge clk) begin
    if (wr_en && addr == ADDR_DOUT) dout_q <= wr_data;
  end

  always_comb begin
    case (addr)
      ADDR_SEL:  rd_next = sel_q;
      ADDR_DIR:  rd_next = dir_q;
      ADDR_DOUT: rd_next = dout_q;
      ADDR_DIN:  rd_next = din_sync;
      ADDR_PU:   rd_next = pu_q;
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

  // R1
  reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sel_q == '0 && dir_q == '0 && pu_q == '0));

  // R8
  din_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_DIN) |=>
      ($stable(sel_q) && $stable(dir_q) && $stable(pu_q) && $stable(dout_q)));

  // R8
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (addr > ADDR_PU) |=> (rd_data == '0));

  // R6
  dout_readback_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && addr == ADDR_DOUT) |=> (rd_data == dout_q));
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux (
  input  logic clk,
  input  logic rst,
  input  logic sel,
  input  logic dir,
  input  logic dout,
  input  logic pu_req,
  input  logic periph_out,
  input  logic periph_oe,
  output logic pad_out,
  output logic pad_oe,
  output logic pad_pu
);
  logic out_next;
  logic oe_next;
  logic pu_next;

  always_comb begin
    if (sel) begin
      out_next = periph_out;
      oe_next  = periph_oe;
      pu_next  = 1'b0;
    end else begin
      out_next = dout;
      oe_next  = dir;
      pu_next  = pu_req & ~dir;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= 1'b0;
      pad_oe  <= 1'b0;
      pad_pu  <= 1'b0;
    end else begin
      pad_out <= out_next;
      pad_oe  <= oe_next;
      pad_pu  <= pu_next;
    end
  end

  // R4
  pu_off_in_periph_chk: assert property (@(posedge clk) disable iff (rst)
    sel |=> !pad_pu);

  // R3
  periph_follow_chk: assert property (@(posedge clk) disable iff (rst)
    sel |=> (pad_oe == $past(periph_oe) && pad_out == $past(periph_out)));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPINS-1:0]  wr_data,
  output logic [NPINS-1:0]  rd_data,
  input  logic [NPINS-1:0]  periph_out,
  input  logic [NPINS-1:0]  periph_oe,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pad_pu
);
  logic [NPINS-1:0] din_sync;
  logic [NPINS-1:0] sel_q;
  logic [NPINS-1:0] dir_q;
  logic [NPINS-1:0] dout_q;
  logic [NPINS-1:0] pu_q;

  gpio_sync #(.WIDTH(NPINS)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pad_in),
    .sync_out (din_sync)
  );

  gpio_regs #(.NPINS(NPINS)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .addr     (addr),
    .wr_data  (wr_data),
    .din_sync (din_sync),
    .sel_q    (sel_q),
    .dir_q    (dir_q),
    .dout_q   (dout_q),
    .pu_q     (pu_q),
    .rd_data  (rd_data)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    gpio_pin_mux u_mux (
      .clk        (clk),
      .rst        (rst),
      .sel        (sel_q[p]),
      .dir        (dir_q[p]),
      .dout       (dout_q[p]),
      .pu_req     (pu_q[p]),
      .periph_out (periph_out[p]),
      .periph_oe  (periph_oe[p]),
      .pad_out    (pad_out[p]),
      .pad_oe     (pad_oe[p]),
      .pad_pu     (pad_pu[p])
    );
  end

  // R4
  pu_oe_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    (pad_pu & pad_oe) == '0);

  // R2
  gpio_oe_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_q == '0) |=> (pad_oe == $past(dir_q)));
endmodule

// File: tb/gpio_port_test.sv
module gpio_port_test;
  import gpio_pkg::*;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [N-1:0] wr_data = '0;
  logic [N-1:0] rd_data;
  logic [N-1:0] periph_out = '0;
  logic [N-1:0] periph_oe = '0;
  logic [N-1:0] pad_in = '0;
  logic [N-1:0] pad_out, pad_oe, pad_pu;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  gpio_port #(.NPINS(N)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .periph_out(periph_out), .periph_oe(periph_oe),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
  );

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [N-1:0] v);
    wr_en = 1'b0; addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [N-1:0] v;
    logic [N-1:0] s, d, u, o, po, pe;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 pad_oe", pad_oe, '0);
    check("R1 pad_pu", pad_pu, '0);
    rd(ADDR_SEL, v); check("R1 sel", v, '0);
    rd(ADDR_DIR, v); check("R1 dir", v, '0);
    rd(ADDR_PU, v);  check("R1 pu", v, '0);

    // R10 registered pad outputs, R9 same-cycle read returns old value
    wr(ADDR_DOUT, 8'h00);
    wr(ADDR_DIR, 8'hFF);
    check("R9 read during write", rd_data, 8'h00);
    check("R10 pad_oe not yet", pad_oe, 8'h00);
    @(negedge clk);
    check("R10 pad_oe updated", pad_oe, 8'hFF);
    rd(ADDR_DIR, v); check("R9 read after write", v, 8'hFF);

    // R7 input sync latency, pins driven as outputs
    addr = ADDR_DIN;
    pad_in = 8'h3C;
    @(negedge clk); @(negedge clk);
    check("R7 din not yet", rd_data, 8'h00);
    @(negedge clk);
    check("R7 din visible", rd_data, 8'h3C);

    // R6 readback of dout while peripheral drives and pin differs
    wr(ADDR_DOUT, 8'hA5);
    wr(ADDR_SEL, 8'hFF);
    periph_out = 8'h0F; periph_oe = 8'hFF;
    rd(ADDR_DOUT, v); check("R6 dout readback", v, 8'hA5);

    // R8 din write ignored, unmapped reads zero
    wr(ADDR_PU, 8'h81);
    wr(ADDR_DIN, 8'hFF);
    rd(ADDR_SEL, v);  check("R8 sel kept", v, 8'hFF);
    rd(ADDR_DOUT, v); check("R8 dout kept", v, 8'hA5);
    rd(ADDR_PU, v);   check("R8 pu kept", v, 8'h81);
    rd(ADDR_DIN, v);  check("R8 din is pad", v, 8'h3C);
    for (int a = 5; a < 8; a++) begin
      rd(3'(a), v); check("R8 unmapped", v, '0);
    end

    // R5 dout survives reset
    wr(ADDR_DOUT, 8'h5A);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    rd(ADDR_DOUT, v); check("R5 dout after reset", v, 8'h5A);
    rd(ADDR_SEL, v);  check("R1 sel after reset", v, '0);

    // R2 R3 R4 sweep of all 64 combinations per pin
    for (int k = 0; k < 64; k++) begin
      for (int i = 0; i < N; i++) begin
        int c;
        c = (k + i * 9) % 64;
        s[i] = c[0]; d[i] = c[1]; u[i] = c[2];
        o[i] = c[3]; po[i] = c[4]; pe[i] = c[5];
      end
      periph_out = po; periph_oe = pe;
      wr(ADDR_SEL, s); wr(ADDR_DIR, d); wr(ADDR_DOUT, o); wr(ADDR_PU, u);
      @(negedge clk);
      check("R2 R3 pad_oe", pad_oe, (s & pe) | (~s & d));
      check("R2 R3 pad_out", pad_out, (s & po) | (~s & o));
      check("R4 pad_pu", pad_pu, u & ~s & ~d);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule